// File: doc/BRIEF.md
# Host-Port Program Loader

This block fills program memory from a 16-bit host slave port once the host has completed a handshake. After reset it answers only at its default port address. The host must first send a fixed magic value many times in a row. The next host word then moves the block to a new port address. From that point the status register reads a fixed ready code, which the host polls for.

Once ready, the host streams three kinds of 24-bit values: a word count, a start address, and then one value for each program word. The block writes each program word through a one-cycle RAM write port, to consecutive addresses that begin at the start address. It then raises a single-cycle done pulse, and `start_addr_o` carries the address where execution should begin.

The host write strobe is asynchronous to the core clock. The block synchronizes it and detects its rising edge. The host must hold address and data steady for the whole strobe, and the core clock must run at least three times faster than the host transfer rate.

Top module: `host_boot_loader`

## Requirements
- R1: After reset, the base register holds 8'h2F, so the block answers only at host address 12'h2FE. No RAM write and no done pulse is issued until the host has written to the block.
- R2: A host write is accepted only when the host address equals {base, 4'hE}. A write to any other address has no effect.
- R3: The block leaves the preamble only after 32 consecutive accepted writes of 16'h0037. Any other accepted value during the preamble clears the run count to zero.
- R4: The first accepted write after the preamble is the new port address. Its bits [11:4] become the new base. After that, the old address is ignored and the new one is used.
- R5: A read at the block's current address returns 16'h0000 until relocation is complete and 16'h0013 after it. A read at any other address returns 16'h0000.
- R6: Each 24-bit value takes two accepted writes. The first carries bits [15:0]. The second carries bits [23:16] in its bits [7:0], and its bits [15:8] are ignored.
- R7: The first 24-bit value is the word count and the second is the start address. Program word i is written with one `ram_we_o` pulse at address start+i, modulo 2^24.
- R8: After the last program word, `done_o` pulses for exactly one cycle while `start_addr_o` equals the start address. A word count of zero gives the done pulse directly after the start address, with no RAM write.
- R9: After the done pulse, further host writes cause no RAM write and no further done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 12 | Host bus address |
| host_data_i | input | 16 | Host write data |
| host_wr_i | input | 1 | Host write strobe, asynchronous, active high |
| host_rdata_o | output | 16 | Status read data for the addressed register |
| ram_we_o | output | 1 | Program RAM write enable, one cycle per word |
| ram_addr_o | output | 24 | Program RAM write address |
| ram_wdata_o | output | 24 | Program RAM write data |
| done_o | output | 1 | Single-cycle pulse: loading finished |
| start_addr_o | output | 24 | Address where execution begins |

## Verification
On every cycle, the assertions check the following:
- Successive RAM writes after a reset go to consecutive addresses.
- The done pulse lasts one cycle and is never followed by another write or another done pulse.
- The read data is only ever zero or the ready code.
- Once the ready state is reached, it stays set.

The following can only be shown by the bench's scenarios:
- The magic count is cleared by a stray value.
- Relocation takes effect, and the old address is ignored afterwards.
- The two halves of each 24-bit value are assembled correctly.
- The stored data is correct, including wrap-around at the top of the address space and a zero word count.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  typedef enum logic [2:0] {
    ST_MAGIC,
    ST_RELOC,
    ST_CNT,
    ST_ADDR,
    ST_DATA,
    ST_DONE,
    ST_FIN
  } hbl_state_e;
endpackage

// File: rtl/hbl_strobe_sync.sv
module hbl_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  // last synchronized stage vs. one extra delay
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hbl_addr_match.sv
module hbl_addr_match #(
  parameter int HAW = 12,
  parameter int BW  = 8,
  localparam int OW = HAW - BW,
  parameter logic [OW-1:0] OFS = 4'hE
) (
  input  logic [HAW-1:0] addr_i,
  input  logic [BW-1:0]  base_i,
  output logic           match_o
);
  assign match_o = (addr_i == {base_i, OFS});
endmodule

// File: rtl/hbl_word_asm.sv
module hbl_word_asm #(
  parameter int DW = 16,
  parameter int WW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          stb_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [WW-1:0] word_o
);
  localparam int HW = WW - DW;

  logic          half_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      lo_q   <= '0;
    end else if (en_i && stb_i) begin
      if (!half_q) begin
        lo_q   <= data_i;
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
      end
    end
  end

  assign valid_o = en_i & stb_i & half_q;
  assign word_o  = {data_i[HW-1:0], lo_q};
endmodule

// File: rtl/host_boot_loader.sv
module host_boot_loader
  import hbl_pkg::*;
#(
  parameter int HAW         = 12,
  parameter int HDW         = 16,
  parameter int AW          = 24,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAGIC_REPS  = 32,
  parameter logic [BW-1:0]      BASE_RST     = 8'h2F,
  parameter logic [HAW-BW-1:0]  REG_OFS      = 4'hE,
  parameter logic [HDW-1:0]     MAGIC        = 16'h0037,
  parameter logic [HDW-1:0]     READY_STATUS = 16'h0013
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [HAW-1:0] host_addr_i,
  input  logic [HDW-1:0] host_data_i,
  input  logic           host_wr_i,
  output logic [HDW-1:0] host_rdata_o,
  output logic           ram_we_o,
  output logic [AW-1:0]  ram_addr_o,
  output logic [AW-1:0]  ram_wdata_o,
  output logic           done_o,
  output logic [AW-1:0]  start_addr_o
);
  localparam int OW  = HAW - BW;
  localparam int MCW = $clog2(MAGIC_REPS + 1);
  localparam logic [MCW-1:0] MC_LAST = MCW'(MAGIC_REPS - 1);

  hbl_state_e     state_q;
  logic [BW-1:0]  base_q;
  logic [MCW-1:0] mcnt_q;
  logic [AW-1:0]  remain_q, waddr_q, start_q;
  logic [AW-1:0]  ram_addr_q, ram_wdata_q;
  logic           ram_we_q, done_q;

  logic           wr_rise, hit, acc, load_phase, wvalid, ready;
  logic [AW-1:0]  word;

  hbl_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (host_wr_i),
    .rise_o   (wr_rise)
  );

  hbl_addr_match #(.HAW(HAW), .BW(BW), .OFS(REG_OFS)) u_match (
    .addr_i  (host_addr_i),
    .base_i  (base_q),
    .match_o (hit)
  );

  assign acc        = wr_rise & hit;
  assign load_phase = (state_q == ST_CNT) || (state_q == ST_ADDR) || (state_q == ST_DATA);

  hbl_word_asm #(.DW(HDW), .WW(AW)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (load_phase),
    .stb_i   (acc),
    .data_i  (host_data_i),
    .valid_o (wvalid),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_MAGIC;
      base_q      <= BASE_RST;
      mcnt_q      <= '0;
      remain_q    <= '0;
      waddr_q     <= '0;
      start_q     <= '0;
      ram_we_q    <= 1'b0;
      ram_addr_q  <= '0;
      ram_wdata_q <= '0;
      done_q      <= 1'b0;
    end else begin
      ram_we_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_MAGIC: if (acc) begin
          if (host_data_i != MAGIC) begin
            mcnt_q <= '0;
          end else if (mcnt_q == MC_LAST) begin
            mcnt_q  <= '0;
            state_q <= ST_RELOC;
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end
        ST_RELOC: if (acc) begin
          base_q  <= host_data_i[HAW-1:OW];
          state_q <= ST_CNT;
        end
        ST_CNT: if (wvalid) begin
          remain_q <= word;
          state_q  <= ST_ADDR;
        end
        ST_ADDR: if (wvalid) begin
          start_q <= word;
          waddr_q <= word;
          state_q <= (remain_q == '0) ? ST_DONE : ST_DATA;
        end
        ST_DATA: if (wvalid) begin
          ram_we_q    <= 1'b1;
          ram_addr_q  <= waddr_q;
          ram_wdata_q <= word;
          waddr_q     <= waddr_q + 1'b1;
          remain_q    <= remain_q - 1'b1;
          if (remain_q == AW'(1)) state_q <= ST_DONE;
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_FIN;
        end
        default: ;
      endcase
    end
  end

  assign ready        = (state_q != ST_MAGIC) && (state_q != ST_RELOC);
  assign host_rdata_o = hit ? (ready ? READY_STATUS : '0) : '0;
  assign ram_we_o     = ram_we_q;
  assign ram_addr_o   = ram_addr_q;
  assign ram_wdata_o  = ram_wdata_q;
  assign done_o       = done_q;
  assign start_addr_o = start_q;
endmodule

// File: rtl/hbl_chk.sv
module hbl_chk #(
  parameter int AW  = 24,
  parameter int HDW = 16,
  parameter logic [HDW-1:0] READY = 16'h0013
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ram_we_i,
  input logic [AW-1:0]  ram_addr_i,
  input logic           done_i,
  input logic [HDW-1:0] rdata_i,
  input logic           ready_i
);
  logic          have_prev_q, done_seen_q;
  logic [AW-1:0] prev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      done_seen_q <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      if (ram_we_i) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= ram_addr_i;
      end
      if (done_i) done_seen_q <= 1'b1;
    end
  end

  // R7
  consecutive_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_i && have_prev_q) |-> (ram_addr_i == prev_addr_q + 1'b1));

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_seen_q |-> (!ram_we_i && !done_i));

  // R5
  status_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i == '0) || (rdata_i == READY));

  // R5
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> ready_i);
endmodule

bind host_boot_loader hbl_chk #(.AW(AW), .HDW(HDW), .READY(READY_STATUS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ram_we_i   (ram_we_o),
  .ram_addr_i (ram_addr_o),
  .done_i     (done_o),
  .rdata_i    (host_rdata_o),
  .ready_i    (ready)
);

// File: tb/sim_host_boot_loader.sv
module sim_host_boot_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] host_addr_i = '0;
  logic [15:0] host_data_i = '0;
  logic        host_wr_i = 1'b0;
  logic [15:0] host_rdata_o;
  logic        ram_we_o;
  logic [23:0] ram_addr_o, ram_wdata_o, start_addr_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  int          n_wr = 0;
  int          n_done = 0;
  logic [23:0] log_addr [16];
  logic [23:0] log_data [16];
  logic [23:0] done_addr = '0;

  host_boot_loader u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (ram_we_o) begin
      if (n_wr < 16) begin
        log_addr[n_wr] = ram_addr_o;
        log_data[n_wr] = ram_wdata_o;
      end
      n_wr = n_wr + 1;
    end
    if (done_o) begin
      n_done    = n_done + 1;
      done_addr = start_addr_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    host_wr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    n_wr = 0;
    n_done = 0;
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic hwr(input logic [11:0] a, input logic [15:0] d);
    host_addr_i = a;
    host_data_i = d;
    host_wr_i   = 1'b1;
    repeat (4) @(negedge clk_i);
    host_wr_i   = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic w24(input logic [11:0] a, input logic [23:0] v);
    hwr(a, v[15:0]);
    hwr(a, {8'hC3, v[23:16]});  // junk upper byte must be ignored
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk_i);
    host_addr_i = a;
    #1 v = host_rdata_o;
  endtask

  task automatic boot(input logic [11:0] port, input int cnt, input logic [23:0] sa, input int seed);
    logic [15:0] v;
    repeat (32) hwr(12'h2FE, 16'h0037);
    hwr(12'h2FE, {4'h0, port});
    rd(port, v);
    check(v == 16'h0013, "R5 ready at new port", 32'(v), 32'h13);
    w24(port, 24'(cnt));
    w24(port, sa);
    for (int i = 0; i < cnt; i++) w24(port, 24'(24'h5A0000 + i * 24'h013579 + seed));
    repeat (4) @(negedge clk_i);
    check(n_wr == cnt, "R7 write count", 32'(n_wr), 32'(cnt));
    for (int i = 0; i < cnt && i < 16; i++) begin
      check(log_addr[i] == 24'(sa + 24'(i)), "R7 address", 32'(log_addr[i]), 32'(sa + 24'(i)));
      check(log_data[i] == 24'(24'h5A0000 + i * 24'h013579 + seed), "R6 data",
            32'(log_data[i]), 32'(24'h5A0000 + i * 24'h013579 + seed));
    end
    check(n_done == 1, "R8 one done pulse", 32'(n_done), 32'd1);
    check(done_addr == sa, "R8 start address", 32'(done_addr), 32'(sa));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    do_reset();

    // R1 reset state
    rd(12'h2FE, v);
    check(v == 16'h0000, "R1 status at default", 32'(v), 32'h0);
    check(!ram_we_o && !done_o, "R1 outputs idle", {30'b0, ram_we_o, done_o}, 32'h0);

    // R2 magic to a wrong address is ignored
    repeat (32) hwr(12'h3AE, 16'h0037);
    hwr(12'h3AE, 16'h03AE);
    rd(12'h3AE, v);
    check(v == 16'h0000, "R2 foreign address ignored", 32'(v), 32'h0);

    // R3 a stray value clears the run
    repeat (31) hwr(12'h2FE, 16'h0037);
    hwr(12'h2FE, 16'h0038);
    repeat (31) hwr(12'h2FE, 16'h0037);
    rd(12'h2FE, v);
    check(v == 16'h0000, "R3 31 after stray not enough", 32'(v), 32'h0);
    hwr(12'h2FE, 16'h0037);
    rd(12'h2FE, v);
    check(v == 16'h0000, "R5 not ready before relocation", 32'(v), 32'h0);
    hwr(12'h2FE, 16'h04A7);  // R4 new port address 12'h4A7 -> base 8'h4A
    rd(12'h4AE, v);
    check(v == 16'h0013, "R4 relocated to base 4A", 32'(v), 32'h13);
    rd(12'h2FE, v);
    check(v == 16'h0000, "R5 old address reads zero", 32'(v), 32'h0);

    // R4 old address ignored after relocation
    w24(12'h2FE, 24'd2);
    w24(12'h2FE, 24'h000010);
    w24(12'h2FE, 24'h111111);
    w24(12'h2FE, 24'h222222);
    check(n_wr == 0 && n_done == 0, "R4 old address writes ignored", 32'(n_wr + n_done), 32'h0);

    w24(12'h4AE, 24'd3);
    w24(12'h4AE, 24'h12AB34);
    for (int i = 0; i < 3; i++) w24(12'h4AE, 24'(24'h800001 * (i + 1)));
    repeat (4) @(negedge clk_i);
    check(n_wr == 3, "R7 three writes", 32'(n_wr), 32'd3);
    for (int i = 0; i < 3; i++) begin
      check(log_addr[i] == 24'(24'h12AB34 + i), "R7 address", 32'(log_addr[i]), 32'(24'h12AB34 + i));
      check(log_data[i] == 24'(24'h800001 * (i + 1)), "R6 data", 32'(log_data[i]), 32'(24'h800001 * (i + 1)));
    end
    check(n_done == 1 && done_addr == 24'h12AB34, "R8 done with start", 32'(done_addr), 32'h12AB34);

    // R9 writes after done are ignored
    w24(12'h4AE, 24'h777777);
    w24(12'h4AE, 24'h888888);
    repeat (4) @(negedge clk_i);
    check(n_wr == 3 && n_done == 1, "R9 quiet after done", 32'(n_wr * 16 + n_done), 32'h31);

    // sweep word counts 0..6, with one wrap of the address space
    for (int c = 0; c <= 6; c++) begin
      do_reset();
      boot({8'(8'h40 + c), 4'hE}, c, (c == 5) ? 24'hFFFFFD : 24'(24'h001000 * c + c), c);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule